// File: doc/BRIEF.md
# Buffered Timer Time-Base

This block is the counting core of a general-purpose timer. A 16-bit up-counter advances once per counter-clock tick. The tick comes from a prescaler that divides the system clock by a programmable ratio plus one. When the counter reaches a programmable limit, it folds back to zero and produces an update event. An update event can also come from a software strobe or from a plain external reset-trigger input. Every update event sets a sticky interrupt flag.

The division ratio is double-buffered. Software writes a pending ratio, and the running prescaler adopts it only at the next update event. At that moment the internal divide phase also restarts from zero. The limit has no buffer and acts on the next tick. A limit of zero parks the counter.

Software reaches the block through a register port made of a valid strobe, a write flag, a 3-bit word address and 32-bit write data. The port has no back-pressure: every request is accepted in the cycle it is presented. Read data is combinational on the presented address in the same cycle.

Register words, by address:
- 0: control. Bit 0 enables counting, bit 1 enables the flag mirror.
- 1: flag.
- 2: update strobe.
- 3: count.
- 4: pending divide ratio.
- 5: limit.

Top module: `tbu_timebase`

## Requirements
- R1: After reset, all of the following hold: control (address 0) reads 0, the flag (address 1, bit 0) reads 0, count (address 3) reads 0, the pending ratio (address 4) reads 0, the limit (address 5) reads 0xFFFF, and `upd_irq` is low.
- R2: While control bit 0 is 1 and the limit is non-zero, the count rises by one every (active ratio + 1) clock edges. The first increment falls on the (ratio+1)-th edge after enable. With bit 0 cleared, the count holds.
- R3: A write to address 4 reads back at once but leaves the running division unchanged until the next update event. From that event on, the new ratio applies.
- R4: On a tick where count equals the limit, `upd_evt` is high for that cycle. At the next edge the count becomes 0, the flag sets, and the divide phase restarts.
- R5: Writing 1 to bit 0 of address 2 is an update event. It clears the count, loads the pending ratio, restarts the divide phase and sets the flag.
- R6: A one-cycle high on `ext_rst_trig` has the same effect as R5, and `upd_evt` is high in that cycle.
- R7: While the limit is 0, ticks do not change the count.
- R8: Writing 0 to bit 0 of address 1 clears the flag, and writing 1 leaves it unchanged. If an update event and a clearing write fall in the same cycle, the flag ends set.
- R9: Address 3 returns the count in bits 15:0 and zeros in bits 30:16. Bit 31 equals the flag when control bit 1 is 1, and reads 0 otherwise.
- R10: A write to address 3 loads bits 15:0 into the count, and counting continues from that value.
- R11: A new limit is compared from the edge after its write, with no buffering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the prescaler input |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 3 | Register word address; also selects read data |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `req_addr`, same cycle |
| ext_rst_trig | input | 1 | External reset trigger, one update event per high cycle |
| upd_evt | output | 1 | High in the cycle an update event occurs |
| upd_irq | output | 1 | Sticky update interrupt flag |

## Verification
A register write lands on the rising edge that accepts it, and a read is valid within the same cycle. The count steps on the edge that ends a tick cycle, so with ratio P the k-th increment is due k*(P+1) edges after enable. `upd_evt` is combinational in the cycle before the fold, while the zeroed count and the set flag appear one edge later. The bench drives every input at a falling edge and samples just after a later falling edge. It counts the rising edges in between explicitly, so each check lands in the exact cycle its result is due.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_EVT   = 3'd2,
    RA_COUNT = 3'd3,
    RA_DIV   = 3'd4,
    RA_LIMIT = 3'd5
  } reg_addr_e;

  localparam int CTRL_RUN_BIT    = 0;
  localparam int CTRL_MIRROR_BIT = 1;
  localparam int STAT_FLAG_BIT   = 0;
  localparam int EVT_UPD_BIT     = 0;
endpackage

// File: rtl/tbu_regs.sv
module tbu_regs
  import tbu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              upd_evt_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              run_o,
  output logic              mirror_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic [DIV_W-1:0]  div_pre_o,
  output logic              sw_upd_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o
);
  localparam logic [CNT_W-1:0] LIMIT_RST = '1;

  logic wr_en;
  logic hit_ctrl, hit_stat, hit_evt, hit_div, hit_limit;

  assign wr_en     = req_valid && req_write;
  assign hit_ctrl  = wr_en && (req_addr == RA_CTRL);
  assign hit_stat  = wr_en && (req_addr == RA_STAT);
  assign hit_evt   = wr_en && (req_addr == RA_EVT);
  assign hit_div   = wr_en && (req_addr == RA_DIV);
  assign hit_limit = wr_en && (req_addr == RA_LIMIT);

  assign cnt_wr_o    = wr_en && (req_addr == RA_COUNT);
  assign cnt_wdata_o = req_wdata[CNT_W-1:0];
  assign sw_upd_o    = hit_evt && req_wdata[EVT_UPD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o     <= 1'b0;
      mirror_o  <= 1'b0;
      limit_o   <= LIMIT_RST;
      div_pre_o <= '0;
    end else begin
      if (hit_ctrl) begin
        run_o    <= req_wdata[CTRL_RUN_BIT];
        mirror_o <= req_wdata[CTRL_MIRROR_BIT];
      end
      if (hit_limit) limit_o <= req_wdata[CNT_W-1:0];
      if (hit_div)   div_pre_o <= req_wdata[DIV_W-1:0];
    end
  end

  // set has priority over a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_o <= 1'b0;
    else if (upd_evt_i)
      flag_o <= 1'b1;
    else if (hit_stat && !req_wdata[STAT_FLAG_BIT])
      flag_o <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (req_addr)
      RA_CTRL: begin
        rd_data[CTRL_RUN_BIT]    = run_o;
        rd_data[CTRL_MIRROR_BIT] = mirror_o;
      end
      RA_STAT:  rd_data[STAT_FLAG_BIT] = flag_o;
      RA_COUNT: begin
        rd_data[CNT_W-1:0] = count_i;
        rd_data[DATA_W-1]  = mirror_o && flag_o;
      end
      RA_DIV:   rd_data[DIV_W-1:0] = div_pre_o;
      RA_LIMIT: rd_data[CNT_W-1:0] = limit_o;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tbu_prescaler.sv
module tbu_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [DIV_W-1:0] div_pre_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_act;
  logic [DIV_W-1:0] phase;

  assign tick_o = run_i && (phase == div_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act <= '0;
      phase   <= '0;
    end else if (reload_i) begin
      div_act <= div_pre_i;
      phase   <= '0;
    end else if (run_i) begin
      phase <= tick_o ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/tbu_counter.sv
module tbu_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic frozen;

  assign frozen = (limit_i == '0);
  assign wrap_o = tick_i && !frozen && (count_o == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_o <= '0;
    else if (clear_i)
      count_o <= '0;
    else if (wr_i)
      count_o <= wdata_i;
    else if (tick_i && !frozen)
      count_o <= wrap_o ? '0 : count_o + 1'b1;
  end
endmodule

// File: rtl/tbu_timebase.sv
module tbu_timebase
  import tbu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_rst_trig,
  output logic              upd_evt,
  output logic              upd_irq
);
  logic             run, mirror, flag, sw_upd, cnt_wr, tick, wrap;
  logic [CNT_W-1:0] limit, count, cnt_wdata;
  logic [DIV_W-1:0] div_pre;

  assign upd_evt = wrap || sw_upd || ext_rst_trig;
  assign upd_irq = flag;

  tbu_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .count_i(count), .upd_evt_i(upd_evt),
    .rd_data(rd_data), .run_o(run), .mirror_o(mirror), .flag_o(flag),
    .limit_o(limit), .div_pre_o(div_pre), .sw_upd_o(sw_upd),
    .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata)
  );

  tbu_prescaler #(.DIV_W(DIV_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run_i(run), .reload_i(upd_evt),
    .div_pre_i(div_pre), .tick_o(tick)
  );

  tbu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .clear_i(sw_upd || ext_rst_trig), .wr_i(cnt_wr),
    .wdata_i(cnt_wdata), .limit_i(limit),
    .count_o(count), .wrap_o(wrap)
  );
endmodule

// File: rtl/tbu_timebase_chk.sv
module tbu_timebase_chk
  import tbu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_rst_trig,
  input logic              sw_upd,
  input logic              wrap,
  input logic              cnt_wr,
  input logic              mirror,
  input logic              upd_evt,
  input logic              upd_irq,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  limit,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] rd_data
);
  AST_FROZEN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0 && !sw_upd && !ext_rst_trig && !cnt_wr) |=> $stable(count)); // R7
  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_trig |=> (count == '0)); // R6
  AST_SW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_upd |=> (count == '0)); // R5
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cnt_wr) |=> (count == '0)); // R4
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> upd_irq); // R8
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == RA_COUNT) |-> (rd_data[DATA_W-2:CNT_W] == '0)); // R9
  AST_MIRROR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == RA_COUNT && !mirror) |-> !rd_data[DATA_W-1]); // R9
endmodule

bind tbu_timebase tbu_timebase_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rst_trig(ext_rst_trig), .sw_upd(sw_upd),
  .wrap(wrap), .cnt_wr(cnt_wr), .mirror(mirror), .upd_evt(upd_evt),
  .upd_irq(upd_irq), .count(count), .limit(limit),
  .req_addr(req_addr), .rd_data(rd_data)
);

// File: tb/tbu_timebase_tb.sv
`timescale 1ns/1ps
module tbu_timebase_tb;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_EVT = 3'd2,
                         A_COUNT = 3'd3, A_DIV = 3'd4, A_LIMIT = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, ext_rst_trig = 1'b0;
  logic [2:0]  req_addr = 3'd0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        upd_evt, upd_irq;
  int          vectors = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tbu_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .ext_rst_trig(ext_rst_trig), .upd_evt(upd_evt), .upd_irq(upd_irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    req_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic trig_pulse();
    ext_rst_trig = 1'b1;
    #1;
    check("R6 upd_evt during trigger", {31'b0, upd_evt}, 32'd1);
    @(negedge clk);
    ext_rst_trig = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset_state();
    do_reset();
    rd_chk("R1 ctrl", A_CTRL, 32'd0);
    rd_chk("R1 flag", A_STAT, 32'd0);
    rd_chk("R1 count", A_COUNT, 32'd0);
    rd_chk("R1 div", A_DIV, 32'd0);
    rd_chk("R1 limit", A_LIMIT, 32'h0000_FFFF);
    check("R1 upd_irq", {31'b0, upd_irq}, 32'd0);
  endtask

  task automatic t_count_and_hold();
    do_reset();
    wr(A_CTRL, 32'd1);
    step(5);
    rd_chk("R2 count ratio 1", A_COUNT, 32'd5);
    wr(A_CTRL, 32'd0);
    step(4);
    rd_chk("R2 hold when disabled", A_COUNT, 32'd6);
  endtask

  task automatic t_ratio_three();
    do_reset();
    wr(A_DIV, 32'd2);
    wr(A_EVT, 32'd1);
    wr(A_CTRL, 32'd1);
    step(12);
    rd_chk("R2 ratio 3 after 12", A_COUNT, 32'd4);
    step(2);
    rd_chk("R2 ratio 3 between ticks", A_COUNT, 32'd4);
    step(1);
    rd_chk("R2 ratio 3 next tick", A_COUNT, 32'd5);
  endtask

  task automatic t_buffer_and_trigger();
    do_reset();
    wr(A_CTRL, 32'd1);
    wr(A_DIV, 32'd3);
    rd_chk("R3 pending readback", A_DIV, 32'd3);
    step(4);
    rd_chk("R3 old ratio still active", A_COUNT, 32'd5);
    trig_pulse();
    rd_chk("R6 count cleared", A_COUNT, 32'd0);
    check("R6 flag set", {31'b0, upd_irq}, 32'd1);
    step(7);
    rd_chk("R3 new ratio after trigger", A_COUNT, 32'd1);
    step(1);
    rd_chk("R3 new ratio second tick", A_COUNT, 32'd2);
  endtask

  task automatic t_wrap();
    do_reset();
    wr(A_LIMIT, 32'd3);
    wr(A_DIV, 32'd1);
    wr(A_CTRL, 32'd1);
    step(3);
    rd_chk("R4 at limit", A_COUNT, 32'd3);
    check("R4 upd_evt at limit", {31'b0, upd_evt}, 32'd1);
    check("R4 flag before wrap", {31'b0, upd_irq}, 32'd0);
    step(1);
    rd_chk("R4 wrapped", A_COUNT, 32'd0);
    check("R4 flag after wrap", {31'b0, upd_irq}, 32'd1);
    step(2);
    rd_chk("R4 new ratio first tick", A_COUNT, 32'd1);
    step(1);
    rd_chk("R4 new ratio hold", A_COUNT, 32'd1);
  endtask

  task automatic t_sw_update();
    do_reset();
    wr(A_CTRL, 32'd1);
    step(5);
    wr(A_EVT, 32'd1);
    rd_chk("R5 count cleared", A_COUNT, 32'd0);
    rd_chk("R5 flag set", A_STAT, 32'd1);
  endtask

  task automatic t_freeze_and_limit();
    do_reset();
    wr(A_LIMIT, 32'd0);
    wr(A_CTRL, 32'd1);
    step(5);
    rd_chk("R7 frozen count", A_COUNT, 32'd0);
    check("R7 no flag", {31'b0, upd_irq}, 32'd0);
    wr(A_COUNT, 32'd7);
    step(3);
    rd_chk("R7 frozen after load", A_COUNT, 32'd7);
    wr(A_LIMIT, 32'd10);
    step(2);
    rd_chk("R11 counts to new limit", A_COUNT, 32'd9);
    step(2);
    rd_chk("R11 wrap at new limit", A_COUNT, 32'd0);
    check("R11 flag at new limit", {31'b0, upd_irq}, 32'd1);
  endtask

  task automatic t_count_write();
    do_reset();
    wr(A_CTRL, 32'd1);
    wr(A_COUNT, 32'd100);
    rd_chk("R10 loaded", A_COUNT, 32'd100);
    step(3);
    rd_chk("R10 continues", A_COUNT, 32'd103);
  endtask

  task automatic t_flag_and_mirror();
    do_reset();
    wr(A_EVT, 32'd1);
    wr(A_STAT, 32'd1);
    rd_chk("R8 write 1 keeps flag", A_STAT, 32'd1);
    rd_chk("R9 no mirror", A_COUNT, 32'd0);
    wr(A_CTRL, 32'd2);
    wr(A_COUNT, 32'h0000_1234);
    rd_chk("R9 mirror on", A_COUNT, 32'h8000_1234);
    wr(A_STAT, 32'd0);
    rd_chk("R8 flag cleared", A_STAT, 32'd0);
    rd_chk("R9 mirror follows flag", A_COUNT, 32'h0000_1234);
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_STAT; req_wdata = 32'd0;
    ext_rst_trig = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; ext_rst_trig = 1'b0;
    rd_chk("R8 set wins over clear", A_STAT, 32'd1);
  endtask

  initial begin
    t_reset_state();
    t_count_and_hold();
    t_ratio_three();
    t_buffer_and_trigger();
    t_wrap();
    t_sw_update();
    t_freeze_and_limit();
    t_count_write();
    t_flag_and_mirror();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule